// File: doc/BRIEF.md
# Super-I/O Configuration Port Controller

This block guards a configuration register window that sits at two adjacent addresses on a simple 8-bit I/O bus. The lower address is the index port. The address one above it is the data port. The lower address is picked by a strap input, from two fixed choices. After reset the window is locked. In that state it answers no register traffic. Software unlocks it by writing the entry key to the index port twice in a row, and locks it again by writing the exit key to the index port.

While the window is open, a write to the index port chooses a register number. A later access to the data port then reads or writes that register. Register numbers below 0x30 belong to a small global space that this block serves itself. That space holds the logical-device selector and the identification bytes. Register numbers from 0x30 upward belong to whichever logical device is currently selected. For those, the access is passed on through a one-cycle select-and-strobe interface, and the downstream read value is returned on the bus in the same cycle.

Bus reads are combinational: `bus_rdata` is valid in the cycle in which `bus_rd` is high. Register state changes at the clock edge that ends a write cycle.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the window is locked, the key counter is cleared, the index register is 0x00 and `ld_sel` is 0x00.
- R2: The index port is at 0x2E when `strap_alt`=0 and at 0x4E when `strap_alt`=1. The data port is the index port address plus one. Accesses to any other address have no effect and read 0xFF.
- R3: The window opens only after two consecutive writes of 0x87 to the index port. Any other write to either port between the two key writes restarts the count. Reads do not restart it.
- R4: While the window is locked, reads of either port return 0xFF. Writes other than the key leave `ld_sel` unchanged and never raise `dev_req`.
- R5: While the window is open, writing 0xAA to the index port locks it at the next clock edge. That write does not change the index register.
- R6: While the window is open, any other value written to the index port is latched as the register index, and a read of the index port returns it.
- R7: Global register 0x07 holds the logical-device number. It can be read and written through the data port, and it drives `ld_sel`. Device number 0x06 is the GPIO function.
- R8: Reads return the following values: register 0x20 is DEV_ID[15:8], 0x21 is DEV_ID[7:0], 0x22 is DEV_REV, 0x23 is 0x19 and 0x24 is 0x34 (manufacturer 0x1934). Writes to these registers are ignored.
- R9: While the window is open, a data-port access with index 0x30 or above raises `dev_req` in the same cycle, with `dev_idx` equal to the index. A write also raises `dev_we` and puts the written byte on `dev_wdata`. A read returns `dev_rdata` on `bus_rdata`.
- R10: Global registers below 0x30 that are not listed in R7 and R8 read 0x00, and writes to them are ignored. If `bus_wr` and `bus_rd` are both high, the cycle is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base address select: 0 gives 0x2E, 1 gives 0x4E |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| ld_sel | output | 8 | Selected logical device |
| dev_req | output | 1 | Logical-device register access strobe |
| dev_we | output | 1 | The strobed access is a write |
| dev_idx | output | 8 | Logical-device register number |
| dev_wdata | output | 8 | Logical-device write data |
| dev_rdata | input | 8 | Logical-device read data, same cycle |

## Verification
The assertions check the following on every cycle:
- A locked window reads 0xFF and never forwards an access.
- Every forwarded access has an index of at least 0x30.
- The window opens only on the clock edge after a key write.
- The exit key always locks the window.
- `ld_sel` moves only on an open data-port write.

Some behaviours need a sequence of bus operations to show, so only the bench scenarios can cover them. These are the restart of the key counter by a stray write, the value of each identification byte, reads of unused global registers, the two strap choices, and the same-cycle return of downstream read data. The bench's reference model covers them by predicting every read value and strobe, one bus operation at a time.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] KEY_ENTER  = 8'h87;
  localparam logic [7:0] KEY_EXIT   = 8'hAA;
  localparam logic [7:0] REG_LDSEL  = 8'h07;
  localparam logic [7:0] REG_DID_HI = 8'h20;
  localparam logic [7:0] REG_DID_LO = 8'h21;
  localparam logic [7:0] REG_REV    = 8'h22;
  localparam logic [7:0] REG_MID_HI = 8'h23;
  localparam logic [7:0] REG_MID_LO = 8'h24;
  localparam logic [7:0] FWD_FLOOR  = 8'h30;
  localparam logic [15:0] MFR_ID    = 16'h1934;
  localparam logic [7:0] IDLE_READ  = 8'hFF;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_t;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  localparam logic [ADDR_W-1:0] PRI_A = ADDR_W'(BASE_PRI);
  localparam logic [ADDR_W-1:0] ALT_A = ADDR_W'(BASE_ALT);

  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] dat_addr;
  logic              rd_only;
  logic              hit_idx;
  logic              hit_dat;

  generate
    if (PRI_A == ALT_A) begin : g_fixed
      assign idx_addr = PRI_A;
    end else begin : g_strap
      assign idx_addr = strap_alt ? ALT_A : PRI_A;
    end
  endgenerate

  assign dat_addr = idx_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign hit_idx  = (bus_addr == idx_addr);
  assign hit_dat  = (bus_addr == dat_addr);
  assign rd_only  = bus_rd & ~bus_wr;

  assign idx_wr = hit_idx & bus_wr;
  assign idx_rd = hit_idx & rd_only;
  assign dat_wr = hit_dat & bus_wr;
  assign dat_rd = hit_dat & rd_only;
endmodule

// File: rtl/cfgp_lock.sv
module cfgp_lock
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       unlocked
);
  lock_t state_q;
  lock_t state_d;
  logic  state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_LOCKED: begin
        if (idx_wr && wdata == KEY_ENTER) state_d = LK_HALF;
      end
      LK_HALF: begin
        if (idx_wr && wdata == KEY_ENTER) state_d = LK_OPEN;
        else if (idx_wr || dat_wr)        state_d = LK_LOCKED;
      end
      LK_OPEN: begin
        if (idx_wr && wdata == KEY_EXIT)  state_d = LK_LOCKED;
      end
      default: state_d = LK_LOCKED;
    endcase
  end

  assign state_en = idx_wr | dat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= LK_LOCKED;
    else if (state_en) state_q <= state_d;
  end

  assign unlocked = (state_q == LK_OPEN);
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0541,
  parameter logic [7:0]  DEV_REV = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       idx_wr,
  input  logic       idx_rd,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  input  logic [7:0] dev_rdata,
  output logic [7:0] rdata,
  output logic [7:0] ld_sel,
  output logic       dev_req,
  output logic       dev_we,
  output logic [7:0] dev_idx,
  output logic [7:0] dev_wdata
);
  logic [7:0] index_q;
  logic [7:0] ldsel_q;
  logic       index_en;
  logic       ldsel_en;
  logic       fwd;
  logic [7:0] glob_val;

  assign index_en = unlocked & idx_wr & (wdata != KEY_EXIT);
  assign ldsel_en = unlocked & dat_wr & (index_q == REG_LDSEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        index_q <= 8'h00;
    else if (index_en) index_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ldsel_q <= 8'h00;
    else if (ldsel_en) ldsel_q <= wdata;
  end

  always_comb begin
    unique case (index_q)
      REG_LDSEL:  glob_val = ldsel_q;
      REG_DID_HI: glob_val = DEV_ID[15:8];
      REG_DID_LO: glob_val = DEV_ID[7:0];
      REG_REV:    glob_val = DEV_REV;
      REG_MID_HI: glob_val = MFR_ID[15:8];
      REG_MID_LO: glob_val = MFR_ID[7:0];
      default:    glob_val = 8'h00;
    endcase
  end

  assign fwd = (index_q >= FWD_FLOOR);

  always_comb begin
    rdata = IDLE_READ;
    if (unlocked) begin
      if (idx_rd)      rdata = index_q;
      else if (dat_rd) rdata = fwd ? dev_rdata : glob_val;
    end
  end

  assign dev_req   = unlocked & fwd & (dat_wr | dat_rd);
  assign dev_we    = unlocked & fwd & dat_wr;
  assign dev_idx   = index_q;
  assign dev_wdata = wdata;
  assign ld_sel    = ldsel_q;
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E,
  parameter logic [15:0] DEV_ID   = 16'h0541,
  parameter logic [7:0]  DEV_REV  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        ld_sel,
  output logic              dev_req,
  output logic              dev_we,
  output logic [7:0]        dev_idx,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);
  logic idx_wr;
  logic idx_rd;
  logic dat_wr;
  logic dat_rd;
  logic unlocked;

  cfgp_decode #(
    .ADDR_W  (ADDR_W),
    .BASE_PRI(BASE_PRI),
    .BASE_ALT(BASE_ALT)
  ) u_decode (
    .strap_alt(strap_alt),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .idx_wr   (idx_wr),
    .idx_rd   (idx_rd),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd)
  );

  cfgp_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .dat_wr  (dat_wr),
    .wdata   (bus_wdata),
    .unlocked(unlocked)
  );

  cfgp_regs #(
    .DEV_ID (DEV_ID),
    .DEV_REV(DEV_REV)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlocked (unlocked),
    .idx_wr   (idx_wr),
    .idx_rd   (idx_rd),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd),
    .wdata    (bus_wdata),
    .dev_rdata(dev_rdata),
    .rdata    (bus_rdata),
    .ld_sel   (ld_sel),
    .dev_req  (dev_req),
    .dev_we   (dev_we),
    .dev_idx  (dev_idx),
    .dev_wdata(dev_wdata)
  );
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unlocked,
  input logic              strap_alt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        ld_sel,
  input logic              dev_req,
  input logic [7:0]        dev_idx
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] dport;
  logic              i_wr;
  logic              d_wr;
  logic              d_rd;

  assign base  = strap_alt ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_PRI);
  assign dport = base + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign i_wr  = bus_wr && (bus_addr == base);
  assign d_wr  = bus_wr && (bus_addr == dport);
  assign d_rd  = bus_rd && !bus_wr && (bus_addr == dport);

  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && d_rd) |-> (bus_rdata == 8'hFF));

  p_locked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !dev_req);

  p_fwd_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> (dev_idx >= 8'h30));

  p_exit_locks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && i_wr && bus_wdata == 8'hAA) |=> !unlocked);

  p_open_after_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(i_wr && bus_wdata == 8'h87));

  p_ldsel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlocked && d_wr) |=> $stable(ld_sel));
endmodule

bind cfg_port_ctrl cfgp_checker #(
  .ADDR_W  (ADDR_W),
  .BASE_PRI(BASE_PRI),
  .BASE_ALT(BASE_ALT)
) u_cfgp_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .unlocked (unlocked),
  .strap_alt(strap_alt),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .ld_sel   (ld_sel),
  .dev_req  (dev_req),
  .dev_idx  (dev_idx)
);

// File: tb/test_cfg_port_ctrl.sv
module test_cfg_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] T_DEV_ID  = 16'h0541;
  localparam logic [7:0]  T_DEV_REV = 8'h01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_alt;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  ld_sel;
  logic        dev_req;
  logic        dev_we;
  logic [7:0]  dev_idx;
  logic [7:0]  dev_wdata;
  logic [7:0]  dev_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model: 0 locked, 1 one key seen, 2 open
  int         m_state;
  logic [7:0] m_idx;
  logic [7:0] m_ld;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign dev_rdata = dev_idx ^ 8'h5A;

  cfg_port_ctrl #(.DEV_ID(T_DEV_ID), .DEV_REV(T_DEV_REV)) i_cfg_port_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ld_sel(ld_sel), .dev_req(dev_req),
    .dev_we(dev_we), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata)
  );

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] model_reg(logic [7:0] i);
    if (i >= 8'h30) return i ^ 8'h5A;
    case (i)
      8'h07:   return m_ld;
      8'h20:   return T_DEV_ID[15:8];
      8'h21:   return T_DEV_ID[7:0];
      8'h22:   return T_DEV_REV;
      8'h23:   return 8'h19;
      8'h24:   return 8'h34;
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_reset(logic s);
    @(negedge clk);
    rst_n = 1'b0; strap_alt = s; bus_wr = 0; bus_rd = 0;
    bus_addr = 16'h0000; bus_wdata = 8'h00;
    m_state = 0; m_idx = 8'h00; m_ld = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "ld_sel in reset", {8'h00, ld_sel}, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic op(string tag, logic [15:0] a, logic w, logic r, logic [7:0] d);
    logic [15:0] eb;
    logic hi, hd, rdo, ereq;
    logic [7:0] erd;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    #2;
    eb   = strap_alt ? 16'h004E : 16'h002E;
    hi   = (a == eb);
    hd   = (a == eb + 16'd1);
    rdo  = r && !w;
    ereq = (m_state == 2) && hd && (m_idx >= 8'h30);
    erd  = 8'hFF;
    if (m_state == 2 && hi) erd = m_idx;
    if (m_state == 2 && hd) erd = model_reg(m_idx);
    if (rdo) chk(tag, "bus_rdata", {8'h00, bus_rdata}, {8'h00, erd});
    chk(tag, "dev_req", {15'h0, dev_req}, {15'h0, ereq});
    chk(tag, "dev_we", {15'h0, dev_we}, {15'h0, ereq && w});
    if (ereq) chk(tag, "dev_idx", {8'h00, dev_idx}, {8'h00, m_idx});
    if (ereq && w) chk(tag, "dev_wdata", {8'h00, dev_wdata}, {8'h00, d});
    chk(tag, "ld_sel", {8'h00, ld_sel}, {8'h00, m_ld});
    @(posedge clk);
    #1;
    if (w && hi) begin
      case (m_state)
        0: m_state = (d == 8'h87) ? 1 : 0;
        1: m_state = (d == 8'h87) ? 2 : 0;
        default: if (d == 8'hAA) m_state = 0; else m_idx = d;
      endcase
    end else if (w && hd) begin
      if (m_state == 1) m_state = 0;
      else if (m_state == 2 && m_idx == 8'h07) m_ld = d;
    end
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(string tag, logic [15:0] a, logic [7:0] d); op(tag, a, 1'b1, 1'b0, d); endtask
  task automatic rd(string tag, logic [15:0] a);               op(tag, a, 1'b0, 1'b1, 8'h00); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; strap_alt = 1'b0; bus_wr = 0; bus_rd = 0;
    bus_addr = 16'h0; bus_wdata = 8'h0;
    do_reset(1'b0);
    rd("R1", 16'h002F);
    rd("R4", 16'h002E);
    // R4: locked writes have no effect
    wr("R4", 16'h002E, 8'h07);
    wr("R4", 16'h002F, 8'h33);
    rd("R4", 16'h002F);
    // R3: interrupted key sequence restarts
    wr("R3", 16'h002E, 8'h87);
    wr("R3", 16'h002F, 8'h11);
    wr("R3", 16'h002E, 8'h87);
    rd("R3", 16'h002F);
    rd("R3", 16'h002F);
    wr("R3", 16'h002E, 8'h87);
    rd("R6", 16'h002E);
    // R7: device select
    wr("R7", 16'h002E, 8'h07);
    rd("R7", 16'h002F);
    wr("R7", 16'h002F, 8'h06);
    rd("R7", 16'h002F);
    // R8: identification
    for (int i = 8'h20; i <= 8'h24; i++) begin
      wr("R8", 16'h002E, 8'(i));
      rd("R8", 16'h002F);
    end
    wr("R8", 16'h002E, 8'h20);
    wr("R8", 16'h002F, 8'hFF);
    rd("R8", 16'h002F);
    // R10: unused globals
    wr("R10", 16'h002E, 8'h10);
    wr("R10", 16'h002F, 8'h44);
    rd("R10", 16'h002F);
    wr("R10", 16'h002E, 8'h2F);
    rd("R10", 16'h002F);
    op("R10", 16'h002F, 1'b1, 1'b1, 8'h21);
    // R9: forwarding
    wr("R9", 16'h002E, 8'h30);
    wr("R9", 16'h002F, 8'h77);
    rd("R9", 16'h002F);
    wr("R9", 16'h002E, 8'hF0);
    rd("R9", 16'h002F);
    rd("R6", 16'h002E);
    // R2: other addresses ignored while open
    wr("R2", 16'h004F, 8'h12);
    rd("R2", 16'h004F);
    rd("R2", 16'h0030);
    // R5: exit key
    wr("R5", 16'h002E, 8'hAA);
    rd("R5", 16'h002F);
    rd("R5", 16'h002E);
    wr("R5", 16'h002F, 8'h55);
    wr("R5", 16'h002E, 8'h87);
    wr("R5", 16'h002E, 8'h87);
    rd("R5", 16'h002E);
    // R2: alternate strap
    do_reset(1'b1);
    wr("R2", 16'h002E, 8'h87);
    wr("R2", 16'h002E, 8'h87);
    rd("R2", 16'h004F);
    wr("R2", 16'h004E, 8'h87);
    wr("R2", 16'h004E, 8'h87);
    wr("R2", 16'h004E, 8'h07);
    rd("R2", 16'h004F);
    wr("R2", 16'h002F, 8'h99);
    wr("R7", 16'h004F, 8'h06);
    rd("R7", 16'h004F);
    wr("R9", 16'h004E, 8'hFF);
    rd("R9", 16'h004F);
    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule